// File: doc/BRIEF.md
# Single-Error LFSR Root Locator

This block finds the error position of a code block whose error-locator polynomial has degree one, Λ(x) = 1 + λ1·x. It takes the place of a full Chien search for the single-error case. Only λ1 has to be loaded, because the constant term of Λ is always 1 and subtraction in a binary field is the same as addition. A register takes λ1 on an accepted start. While the block is running, that register is multiplied by α once per codeword position, and a position is flagged when the register reaches the field element 1. The field size, the primitive polynomial, the codeword length and the number of positions handled per cycle are parameters.

With P = 1 the block emits one flag bit per cycle. With P > 1 the register advances P steps per cycle. Each cycle its value is compared with P constants, α^-0 up to α^-(P-1), to find which of the P positions in that cycle, if any, holds the error. The stream is framed by out_valid, and a one-cycle done pulse follows the last beat.

Top module: `sel_root_locator`

## Requirements
- R1: After reset, busy, out_valid, done and err_zero are all 0, and out_flags is all zero.
- R2: A start while busy is 0 loads lambda1. On the following cycle out_valid rises and stays 1 for exactly ceil(N/P) consecutive cycles. Beat b carries positions b·P+p on out_flags[p].
- R3: Position k is flagged (bit set to 1) if and only if λ1·α^k = 1 in GF(2^M). The field is built from POLY, which holds the generator's low-order terms with bit i standing for x^i. The field element 1 is the value 1 and α is the value 2. Every other position reads 0.
- R4: At most one position of a stream is flagged. When λ1 is nonzero and N = 2^M−1, exactly one position is flagged.
- R5: In a final beat that is only partly filled, the bits for positions at or beyond N read 0.
- R6: done is a single-cycle pulse in the cycle after the last beat, and busy is 0 in that cycle.
- R7: When lambda1 = 0 is accepted, no position is flagged. err_zero is 1 from the cycle after that start until the next accepted start whose lambda1 is nonzero.
- R8: A start raised while busy is 1 is ignored: the running stream and its flag position are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a search; accepted only when busy is 0 |
| lambda1 | input | M | First-order locator coefficient, polynomial basis |
| busy | output | 1 | A search stream is in progress |
| out_valid | output | 1 | out_flags carries a beat of the stream |
| out_flags | output | P | Error flags for positions b·P+0 … b·P+P−1 |
| done | output | 1 | One-cycle pulse after the last beat |
| err_zero | output | 1 | The accepted lambda1 was zero |

## Verification
The hardest condition to reach from the ports is a final beat that is only partly filled while its valid lane carries the flag. This needs a width P that does not divide N, and a λ1 whose root falls in the last beat. The bench therefore runs a serial instance and a three-wide instance side by side over a seven-position codeword, and sweeps λ1 over every field element, so that the root passes through every lane and through the one-position tail. A start raised in the middle of a stream with a different coefficient shows that the flag position does not move.

// File: rtl/sel_gf_pkg.sv
package sel_gf_pkg;

   // One multiply by alpha on an m-bit field element held in a 32-bit word.
   function automatic logic [31:0] gf_xtime(input logic [31:0] v, input logic [31:0] poly,
                                            input int unsigned m);
      logic [31:0] mask;
      logic [31:0] r;
      mask = (32'd1 << m) - 32'd1;
      r = (v << 1) & mask;
      if (v[m-1]) r = r ^ poly;
      return r & mask;
   endfunction

   // alpha raised to e, by repeated stepping from the element 1.
   function automatic logic [31:0] gf_alpha_pow(input int unsigned e, input logic [31:0] poly,
                                                input int unsigned m);
      logic [31:0] r;
      r = 32'd1;
      for (int unsigned i = 0; i < e; i++) r = gf_xtime(r, poly, m);
      return r;
   endfunction

endpackage

// File: rtl/sel_gf_step.sv
module sel_gf_step #(
   parameter int unsigned M = 3,
   parameter logic [M-1:0] POLY = 3'b011,
   parameter int unsigned P = 1
) (
   input  logic [M-1:0] cur,
   output logic [M-1:0] nxt
);
   logic [M-1:0] chain [0:P];

   assign chain[0] = cur;

   for (genvar g = 0; g < P; g++) begin : g_step
      assign chain[g+1] = {chain[g][M-2:0], 1'b0} ^ (chain[g][M-1] ? POLY : '0);
   end

   assign nxt = chain[P];
endmodule

// File: rtl/sel_root_match.sv
module sel_root_match
   import sel_gf_pkg::*;
#(
   parameter int unsigned M = 3,
   parameter logic [M-1:0] POLY = 3'b011,
   parameter int unsigned P = 1
) (
   input  logic [M-1:0] cur,
   output logic [P-1:0] hit
);
   localparam int unsigned Q = (1 << M) - 1;

   for (genvar g = 0; g < P; g++) begin : g_lane
      localparam logic [31:0] KF = gf_alpha_pow((Q - g) % Q, 32'(POLY), M);
      localparam logic [M-1:0] K = KF[M-1:0];
      assign hit[g] = (cur == K);
   end
endmodule

// File: rtl/sel_beat_ctr.sv
module sel_beat_ctr #(
   parameter int unsigned BEATS = 7,
   localparam int unsigned CW = (BEATS > 1) ? $clog2(BEATS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          run,
   output logic [CW-1:0] cnt,
   output logic          last
);
   assign last = (32'(cnt) == BEATS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (load)          cnt <= '0;
      else if (run && !last)  cnt <= cnt + 1'b1;
   end

   // R2: the beat index never leaves its range
   p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n) 32'(cnt) < BEATS);
endmodule

// File: rtl/sel_root_locator.sv
module sel_root_locator #(
   parameter int unsigned M = 3,
   parameter logic [M-1:0] POLY = 3'b011,
   parameter int unsigned N = 7,
   parameter int unsigned P = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] lambda1,
   output logic         busy,
   output logic         out_valid,
   output logic [P-1:0] out_flags,
   output logic         done,
   output logic         err_zero
);
   localparam int unsigned Q     = (1 << M) - 1;
   localparam int unsigned BEATS = (N + P - 1) / P;
   localparam int unsigned CW    = (BEATS > 1) ? $clog2(BEATS) : 1;

   if (M < 2 || M > 16) begin : g_bad_m
      $error("field width out of range");
   end
   if (N < 1 || N > Q) begin : g_bad_n
      $error("codeword length must lie in 1..2^M-1");
   end
   if (P < 1 || P > N) begin : g_bad_p
      $error("parallel width must lie in 1..N");
   end
   if (POLY[0] != 1'b1) begin : g_bad_poly
      $error("generator must have a constant term");
   end

   logic [M-1:0]  acc;
   logic [M-1:0]  acc_nxt;
   logic [P-1:0]  hit;
   logic [P-1:0]  lane_ok;
   logic [CW-1:0] cnt;
   logic          last;
   logic          accept;

   assign accept = start && !busy;

   sel_gf_step #(.M(M), .POLY(POLY), .P(P)) u_step (.cur(acc), .nxt(acc_nxt));
   sel_root_match #(.M(M), .POLY(POLY), .P(P)) u_match (.cur(acc), .hit(hit));
   sel_beat_ctr #(.BEATS(BEATS)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(accept), .run(busy), .cnt(cnt), .last(last)
   );

   always_comb begin
      for (int g = 0; g < int'(P); g++) begin
         lane_ok[g] = (int'(cnt) * int'(P) + g) < int'(N);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         err_zero <= 1'b0;
      end else if (accept) begin
         acc      <= lambda1;
         busy     <= 1'b1;
         done     <= 1'b0;
         err_zero <= (lambda1 == '0);
      end else if (busy) begin
         acc  <= acc_nxt;
         busy <= !last;
         done <= last;
      end else begin
         done <= 1'b0;
      end
   end

   assign out_valid = busy;
   assign out_flags = busy ? (hit & lane_ok) : '0;

   // Flag tally of the current stream, used only by the checks below.
   logic seen_hit;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  seen_hit <= 1'b0;
      else if (accept)             seen_hit <= 1'b0;
      else if (busy && |out_flags) seen_hit <= 1'b1;
   end

   // R4: one lane at most within a beat
   p_flags_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(out_flags));
   // R4: no second flag once a flag has been given in this stream
   p_single_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && seen_hit) |-> (out_flags == '0));
   // R6: the last beat is followed by done with busy low
   p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && last) |=> (done && !busy));
   // R6: done never lasts two cycles
   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
   // R7: a zero coefficient raises the flag
   p_zero_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && lambda1 == '0) |=> err_zero);
   // R7: a zero coefficient never flags a position
   p_zero_noflag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_zero |-> (out_flags == '0));
   // R8: a running stream is not cut short by a new start
   p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
endmodule

// File: tb/sel_root_locator_tb.sv
module sel_root_locator_tb_top;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [2:0] lambda1 = '0;

   logic s_busy, s_valid, s_done, s_err;
   logic [0:0] s_flags;
   logic p_busy, p_valid, p_done, p_err;
   logic [2:0] p_flags;

   int n_tests = 0;
   int n_fail = 0;
   int pw [0:6];

   always #(CLK_PERIOD/2) clk = ~clk;

   sel_root_locator #(.M(3), .POLY(3'b011), .N(7), .P(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .lambda1(lambda1),
      .busy(s_busy), .out_valid(s_valid), .out_flags(s_flags), .done(s_done), .err_zero(s_err));

   sel_root_locator #(.M(3), .POLY(3'b011), .N(7), .P(3)) dut_par_i (
      .clk(clk), .rst_n(rst_n), .start(start), .lambda1(lambda1),
      .busy(p_busy), .out_valid(p_valid), .out_flags(p_flags), .done(p_done), .err_zero(p_err));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference: carry-less product reduced by x^3 = x + 1.
   function automatic int ref_mul(input int a, input int b);
      int r = 0;
      for (int i = 0; i < 3; i++) if (b[i]) r = r ^ (a << i);
      for (int d = 4; d >= 3; d--) if (r[d]) r = r ^ (11 << (d - 3));
      return r;
   endfunction

   // Position k with lam * alpha^k == 1, or -1 when none exists.
   function automatic int ref_pos(input int lam);
      for (int k = 0; k < 7; k++) if (ref_mul(lam, pw[k]) == 1) return k;
      return -1;
   endfunction

   task automatic finish_tb();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic t_reset();
      chk(!s_busy && !s_valid && !s_done && !s_err && s_flags == 0, "R1 serial idle", s_busy, 0);
      chk(!p_busy && !p_valid && !p_done && !p_err && p_flags == 0, "R1 wide idle", p_busy, 0);
   endtask

   task automatic t_run(input int lam, input bit poke);
      logic [6:0] sbits = '0;
      logic [8:0] pbits = '0;
      int sc = 0;
      int pc = 0;
      int kp;
      logic [6:0] sexp;
      logic [8:0] pexp;
      @(negedge clk);
      start = 1'b1;
      lambda1 = 3'(lam);
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (s_valid && sc < 7) begin sbits[sc] = s_flags[0]; sc++; end
         if (p_valid && pc < 3) begin pbits[pc*3 +: 3] = p_flags; pc++; end
         chk(s_done == (i == 7), $sformatf("R6 serial done lam=%0d i=%0d", lam, i), s_done, i == 7);
         chk(p_done == (i == 3), $sformatf("R6 wide done lam=%0d i=%0d", lam, i), p_done, i == 3);
         if (i == 7) chk(!s_busy, "R6 serial busy low", s_busy, 0);
         if (i == 3) chk(!p_busy, "R6 wide busy low", p_busy, 0);
         if (poke && i == 1) begin start = 1'b1; lambda1 = 3'(lam ^ 5); end
         else start = 1'b0;
         @(negedge clk);
      end
      start = 1'b0;
      kp = ref_pos(lam);
      sexp = (kp >= 0) ? 7'(1 << kp) : '0;
      pexp = (kp >= 0) ? 9'(1 << kp) : '0;
      chk(sc == 7, $sformatf("R2 serial beats lam=%0d", lam), sc, 7);
      chk(pc == 3, $sformatf("R2 wide beats lam=%0d", lam), pc, 3);
      chk(sbits == sexp, $sformatf("R3 R8 serial stream lam=%0d", lam), sbits, sexp);
      chk(pbits == pexp, $sformatf("R3 R5 R8 wide stream lam=%0d", lam), pbits, pexp);
      chk(pbits[8:7] == 0, $sformatf("R5 tail lanes lam=%0d", lam), pbits[8:7], 0);
      chk($countones(sbits) == ((lam != 0) ? 1 : 0), $sformatf("R4 one flag lam=%0d", lam),
          $countones(sbits), lam != 0);
      chk(s_err == (lam == 0) && p_err == (lam == 0), $sformatf("R7 err_zero lam=%0d", lam),
          s_err, lam == 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      finish_tb();
   end

   initial begin
      pw[0] = 1;
      for (int i = 1; i < 7; i++) pw[i] = ref_mul(pw[i-1], 2);
      #(CLK_PERIOD * 3);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      for (int lam = 1; lam < 8; lam++) t_run(lam, 1'b0);
      t_run(0, 1'b0);
      t_run(6, 1'b0);
      t_run(3, 1'b1);
      t_run(0, 1'b1);
      t_run(4, 1'b1);
      finish_tb();
   end
endmodule